// File: doc/BRIEF.md
# Resistor-Ladder Keypad Decoder

This block turns a stream of converter samples into a clean key report. Four switches share one analog input through a resistor ladder, so each switch pulls the input into its own voltage band. The block receives the samples already digitised. Each sample comes with a one-cycle strobe and carries an 8-bit value. The block adds 16 samples into a 12-bit running sum. The top four bits of that sum are the average, expressed as a 4-bit code.

When the ladder node moves between bands it does so slowly, and on the way it passes through codes that belong to other keys. Because of that, the block only trusts a code after two windows in a row produce the same value. A qualifier state machine tracks this. It has two states, `Q_UNSETTLED` and `Q_SETTLED`, and it is evaluated once at the close of every window:
- From `Q_UNSETTLED` it moves to `Q_SETTLED` on a match with the previous code (transition "agree").
- From `Q_SETTLED` it falls back to `Q_UNSETTLED` on a mismatch (transition "disagree").
- On all other window closes it stays where it is.

A banded lookup then maps the settled code to one of four keys or to "none". The key identifier updates only at a window boundary. A one-cycle event pulse marks every change of the reported key, and this includes a change to none.

Top module: `keyladder_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle that follows it, `key_id` is 0, `key_stable` is 0 and `key_event` is 0.
- R2: A window closes after exactly 16 cycles in which `smp_valid` is high, whether or not idle cycles fall between them. Its code is bits 11:8 of the sum of the 16 8-bit samples, which is floor(sum/256).
- R3: After reset the stored previous code is 13. A first window whose code is 13 therefore asserts `key_stable`.
- R4: At each window close, `key_stable` becomes 1 if the new code equals the previous window's code and 0 otherwise. It does not change between window closes.
- R5: A code of 13, 14 or 15 reports `key_id` = 0 (none), whatever the state of `key_stable`.
- R6: `key_id` encoding: 0 = none, 1 = SW1 for codes 0–3, 2 = SW2 for codes 4–6, 3 = SW3 for codes 7–9, 4 = SW4 for codes 10–12.
- R7: When `key_stable` is 0, `key_id` is 0.
- R8: `key_id` and `key_stable` change only in the third cycle after the strobe that closes a window. They hold their values while the next window fills.
- R9: `key_event` is high for exactly one cycle, the cycle in which `key_id` takes a value different from the one it had before. This includes a change to 0.
- R10: Strobes that arrive while `rst` is high are not counted. A window that was partly filled when reset arrived is discarded.
- R11: A sequence of windows whose codes all differ from one window to the next never reports a key other than none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 8 | Upper eight bits of the conversion result |
| key_id | output | 3 | Reported key: 0 none, 1..4 SW1..SW4 |
| key_stable | output | 1 | The last two windows produced the same code |
| key_event | output | 1 | One-cycle pulse when `key_id` changes |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a 16-sample window, a 4-bit code and 13 as the no-key code. With these values a window filled with one repeated sample v always gives code v/16. That lets every one of the sixteen codes be reached directly, including both edges of every band and the 12/13 boundary. Mixed-value windows and strobes separated by idle cycles exercise the averaging and the rule that only strobed cycles are counted. Ramps of changing codes, and a reset that arrives in the middle of a window, exercise the two-window agreement and the discarding of a partly filled window.

// File: rtl/keyladder_pkg.sv
package keyladder_pkg;

    // Reported key identifier: 0 means no key.
    typedef enum logic [2:0] {
        KEY_NONE = 3'd0,
        KEY_SW1  = 3'd1,
        KEY_SW2  = 3'd2,
        KEY_SW3  = 3'd3,
        KEY_SW4  = 3'd4
    } key_e;

    // Qualifier state: whether the last two windows agreed.
    typedef enum logic {
        Q_UNSETTLED = 1'b0,
        Q_SETTLED   = 1'b1
    } qual_e;

    localparam int NUM_KEYS = 4;

endpackage

// File: rtl/window_accum.sv
module window_accum #(
    parameter int SAMPLE_W = 8,
    parameter int WIN_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                win_close,
    output logic [WIN_LOG2-1:0] win_code
);

    localparam int ACC_W   = SAMPLE_W + WIN_LOG2;
    localparam int WIN_LEN = 1 << WIN_LOG2;
    localparam int CNT_W   = WIN_LOG2 + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum_next;
    logic [CNT_W-1:0] cnt_q;
    logic             last_smp;

    // Sum including the current sample; the carry grows into the upper bits.
    assign sum_next = acc_q + {{WIN_LOG2{1'b0}}, smp_data};
    assign last_smp = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            cnt_q     <= CNT_W'(WIN_LEN);
            win_close <= 1'b0;
            win_code  <= '0;
        end else begin
            win_close <= 1'b0;
            if (smp_valid) begin
                if (last_smp) begin
                    // The window ends: take the average, then start a fresh sum.
                    acc_q     <= '0;
                    cnt_q     <= CNT_W'(WIN_LEN);
                    win_close <= 1'b1;
                    win_code  <= sum_next[ACC_W-1 -: WIN_LOG2];
                end else begin
                    acc_q <= sum_next;
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    // R2: the down-counter stays inside 1..WIN_LEN.
    p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(WIN_LEN)));

    // R2: a window only closes on an accepted strobe.
    p_close_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        win_close |-> $past(smp_valid));

    // R2: after a close the counter has been reloaded to a full window.
    p_reload_after_close_r2: assert property (@(posedge clk) disable iff (rst)
        win_close |-> (cnt_q == CNT_W'(WIN_LEN)));

endmodule

// File: rtl/code_qualifier.sv
module code_qualifier
    import keyladder_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int NOKEY_CODE = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_close,
    input  logic [CODE_W-1:0] win_code,
    output logic              upd,
    output logic [CODE_W-1:0] cur_code,
    output logic              settled
);

    qual_e             state_q;
    qual_e             state_d;
    logic [CODE_W-1:0] prev_q;
    logic              code_match;

    assign code_match = (win_code == prev_q);

    // Next-state logic; only a window close can move the machine.
    always_comb begin
        state_d = state_q;
        if (win_close) begin
            unique case (state_q)
                Q_UNSETTLED: if (code_match)  state_d = Q_SETTLED;   // agree
                Q_SETTLED:   if (!code_match) state_d = Q_UNSETTLED; // disagree
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= Q_UNSETTLED;
        end else begin
            state_q <= state_d;
        end
    end

    // Stored code and update strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= CODE_W'(NOKEY_CODE);
            upd    <= 1'b0;
        end else begin
            upd <= win_close;
            if (win_close) begin
                prev_q <= win_code;
            end
        end
    end

    assign cur_code = prev_q;
    assign settled  = (state_q == Q_SETTLED);

    // R4: qualifier state and stored code hold between window closes.
    p_hold_between_r4: assert property (@(posedge clk) disable iff (rst)
        !win_close |=> ($stable(state_q) && $stable(prev_q)));

    // R4: equal codes settle, different codes unsettle.
    p_match_settles_r4: assert property (@(posedge clk) disable iff (rst)
        (win_close && (win_code == prev_q)) |=> settled);

    p_mismatch_unsettles_r4: assert property (@(posedge clk) disable iff (rst)
        (win_close && (win_code != prev_q)) |=> !settled);

endmodule

// File: rtl/band_decoder.sv
module band_decoder
    import keyladder_pkg::*;
#(
    parameter int                           CODE_W     = 4,
    parameter int                           NOKEY_CODE = 13,
    // Lower code bound of SW2, SW3 and SW4, lowest band in the low slice.
    parameter logic [(NUM_KEYS-1)*CODE_W-1:0] BAND_LO  = {4'd10, 4'd7, 4'd4}
) (
    input  logic [CODE_W-1:0] code,
    input  logic              settled,
    output key_e              key
);

    localparam int UPPER_BANDS = NUM_KEYS - 1;

    logic [CODE_W-1:0] lo_bound [UPPER_BANDS];
    key_e              band_key;

    genvar g;
    generate
        for (g = 0; g < UPPER_BANDS; g++) begin : g_bounds
            assign lo_bound[g] = BAND_LO[g*CODE_W +: CODE_W];
        end
    endgenerate

    // Highest band whose lower bound the code reaches wins.
    always_comb begin
        band_key = KEY_SW1;
        for (int i = 0; i < UPPER_BANDS; i++) begin
            if (code >= lo_bound[i]) begin
                band_key = key_e'(3'(i + 2));
            end
        end
    end

    // The no-key range is checked first and overrides the qualifier.
    always_comb begin
        if (code >= CODE_W'(NOKEY_CODE)) begin
            key = KEY_NONE;
        end else if (!settled) begin
            key = KEY_NONE;
        end else begin
            key = band_key;
        end
    end

endmodule

// File: rtl/keyladder_decoder.sv
module keyladder_decoder
    import keyladder_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int WIN_LOG2   = 4,
    parameter int NOKEY_CODE = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [2:0]          key_id,
    output logic                key_stable,
    output logic                key_event
);

    localparam int CODE_W = WIN_LOG2;

    logic              win_close;
    logic [CODE_W-1:0] win_code;
    logic              upd;
    logic [CODE_W-1:0] cur_code;
    logic              settled;
    key_e              dec_key;
    key_e              key_q;
    logic              stable_q;
    logic              event_q;

    window_accum #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .win_close (win_close),
        .win_code  (win_code)
    );

    code_qualifier #(
        .CODE_W     (CODE_W),
        .NOKEY_CODE (NOKEY_CODE)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .win_close (win_close),
        .win_code  (win_code),
        .upd       (upd),
        .cur_code  (cur_code),
        .settled   (settled)
    );

    band_decoder #(
        .CODE_W     (CODE_W),
        .NOKEY_CODE (NOKEY_CODE)
    ) u_band (
        .code    (cur_code),
        .settled (settled),
        .key     (dec_key)
    );

    // Output registers: refreshed once per window, one cycle after qualification.
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q    <= KEY_NONE;
            stable_q <= 1'b0;
            event_q  <= 1'b0;
        end else begin
            event_q <= 1'b0;
            if (upd) begin
                key_q    <= dec_key;
                stable_q <= settled;
                event_q  <= (dec_key != key_q);
            end
        end
    end

    assign key_id     = key_q;
    assign key_stable = stable_q;
    assign key_event  = event_q;

    // R1: reset clears every output.
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> ((key_id == 3'd0) && !key_stable && !key_event));

    // R5: a no-key code always reports none.
    p_highcode_none_r5: assert property (@(posedge clk) disable iff (rst)
        (upd && (cur_code >= CODE_W'(NOKEY_CODE))) |=> (key_id == 3'd0));

    // R7: an unsettled report never names a key.
    p_unstable_none_r7: assert property (@(posedge clk) disable iff (rst)
        !key_stable |-> (key_id == 3'd0));

    // R8: the report only moves on a qualifier update.
    p_hold_until_close_r8: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(key_id) && $stable(key_stable)));

    // R9: the event pulse coincides exactly with a change of key.
    p_event_on_change_r9: assert property (@(posedge clk) disable iff (rst)
        key_event == (key_id != $past(key_id)));

endmodule

// File: tb/keyladder_decoder_tb.sv
module keyladder_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = 8'd0;
    logic [2:0] key_id;
    logic       key_stable;
    logic       key_event;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Reference model state, following the requirements.
    int m_prev   = 13;
    int m_stable = 0;
    int m_key    = 0;

    always #5 clk = ~clk;

    keyladder_decoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .key_id     (key_id),
        .key_stable (key_stable),
        .key_event  (key_event)
    );

    function automatic int band_of(int code);
        if (code >= 13) return 0;
        if (code <= 3)  return 1;
        if (code <= 6)  return 2;
        if (code <= 9)  return 3;
        return 4;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset with optional strobes during reset (R10), then check the outputs (R1).
    task automatic do_reset(input int strobes);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            smp_valid = (strobes != 0);
            smp_data  = 8'hF0;
            @(negedge clk);
            chk("R1 key_id in reset", key_id, 0);
        end
        smp_valid = 1'b0;
        rst = 1'b0;
        m_prev = 13; m_stable = 0; m_key = 0;
        chk("R1 key_id", key_id, 0);
        chk("R1 key_stable", key_stable, 0);
        chk("R1 key_event", key_event, 0);
    endtask

    // One window: 8 samples of a, then 8 of b, with gap idle cycles between strobes.
    task automatic feed_window(input logic [7:0] a, input logic [7:0] b,
                               input int gap, input string req);
        int sum = 0;
        int code;
        int new_key;
        int exp_event;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 8) chk("R8 key holds mid-window", key_id, m_key);
            smp_valid = 1'b1;
            smp_data  = (i < 8) ? a : b;
            sum += (i < 8) ? int'(a) : int'(b);
            if (i < 15) begin
                for (int k = 0; k < gap; k++) begin
                    @(negedge clk);
                    smp_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
        code      = (sum >> 8) & 15;
        m_stable  = (code == m_prev) ? 1 : 0;
        m_prev    = code;
        new_key   = (code >= 13) ? 0 : (m_stable != 0 ? band_of(code) : 0);
        exp_event = (new_key != m_key) ? 1 : 0;
        m_key     = new_key;
        @(negedge clk);
        chk({req, " R8 not yet updated"}, key_event, 0);
        @(negedge clk);
        chk({req, " key_id"}, key_id, m_key);
        chk({req, " R4 key_stable"}, key_stable, m_stable);
        chk({req, " R9 key_event"}, key_event, exp_event);
        @(negedge clk);
        chk({req, " R9 event one cycle"}, key_event, 0);
    endtask

    task automatic same_window(input int code, input string req);
        logic [7:0] v;
        v = 8'((code << 4) | 8);
        feed_window(v, v, 0, req);
    endtask

    task automatic t_idle_codes;
        same_window(14, "R5 first no-key window");
        same_window(14, "R5 settled no-key window");
        same_window(15, "R5 code 15");
    endtask

    task automatic t_press_release;
        same_window(5, "R7 first press unsettled");
        same_window(5, "R6 SW2 settled");
        same_window(13, "R9 release to none");
    endtask

    task automatic t_band_edges;
        int edges [9] = '{0, 3, 4, 6, 7, 9, 10, 12, 13};
        foreach (edges[i]) begin
            same_window(edges[i], "R6 edge first");
            same_window(edges[i], "R6 edge settled");
        end
    endtask

    task automatic t_averaging;
        // 8 x 0x70 + 8 x 0x8F = 2040, code 7; idle gaps between strobes.
        feed_window(8'h70, 8'h8F, 2, "R2 mixed gap first");
        feed_window(8'h70, 8'h8F, 3, "R2 mixed gap settled");
        chk("R2 averaged code to SW3", key_id, 3);
        // 8 x 0x00 + 8 x 0xFF = 2040 as well, a different mix with the same code.
        feed_window(8'h00, 8'hFF, 1, "R2 extreme mix");
        chk("R2 extreme mix keeps SW3", key_id, 3);
    endtask

    task automatic t_ramp;
        for (int c = 12; c >= 0; c -= 2) begin
            same_window(c, "R11 ramp");
            chk("R11 ramp reports none", key_id, 0);
        end
    endtask

    task automatic t_reset_cases;
        // Partly filled window, then reset with strobes active.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = 8'hFF;
        end
        do_reset(1);
        same_window(2, "R10 first after reset");
        same_window(2, "R10 SW1 aligned");
        chk("R10 SW1 reported", key_id, 1);
        do_reset(0);
        same_window(13, "R3 no-key code matches reset value");
        chk("R3 stable at once", key_stable, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        do_reset(0);
        t_idle_codes();
        t_press_release();
        t_band_edges();
        t_averaging();
        t_ramp();
        t_reset_cases();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1 run actual=timeout expected=complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule